// File: doc/BRIEF.md
# I2C Transfer-List Sequencer

This block runs an ordered list of I2C subtransfer descriptors as one bus transaction. The transaction opens with a START and closes with a single STOP after the final descriptor. Each descriptor arrives on a valid/ready channel and carries a 32-bit control word, a byte count and a flag that marks the end of the list. Bytes to transmit arrive on a write byte stream. Bytes received from the bus leave on a read byte stream. A descriptor can instead fold its received bytes into a running checksum.

The sequencer does not toggle SCL or SDA. It drives a byte-level I2C engine over a command channel (START, write byte, read byte with ACK or NACK, STOP) and takes one response per command. A descriptor that continues the previous one adds more bytes in the same direction and sends no START and no address. A NACK from a target, or a malformed list, ends the transaction early. Each list closes with a one-cycle completion pulse that carries a status code and the checksum.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Control word fields: bit 0 is the direction (1 = read, 0 = write), bits 7:1 are the device address, bits 28:8 are reserved, bit 29 is a retry hint, bit 30 selects checksum mode and bit 31 marks a continuation. A descriptor with bit 31 = 0 issues a START command (op 0), or a repeated START if the bus is held, and then a write command (op 1) whose byte is control bits 7:0.
- R2: A descriptor with bit 31 = 1 issues no START, address or STOP. Its bytes follow the previous descriptor's bytes inside the same transaction.
- R3: A write descriptor of length N takes exactly N bytes from the write stream in arrival order and issues each one as a write command (op 1, byte on cmd_wdata).
- R4: A read descriptor of length N issues N read commands (op 2). With bit 30 = 0, each received byte leaves on the read stream in bus order.
- R5: With bit 30 = 1, received bytes are not output. They are added into an accumulator of SUM_W bits that wraps on overflow. The accumulator is cleared when a list's first descriptor is accepted and appears on done_sum at completion.
- R6: A read command carries cmd_nack = 1 only for the last byte of a descriptor that is either the last in the list or followed by a descriptor with bit 31 = 0. Every other read command carries cmd_nack = 0.
- R7: Exactly one STOP command (op 3) is issued per successful list, after the last descriptor's final byte. No STOP is issued between descriptors.
- R8: rsp_ack = 0 after an address or data write aborts the list. The sequencer issues a STOP, consumes the remaining descriptors without bus activity or write-stream reads, and reports status 1.
- R9: A first descriptor with bit 31 = 1 rejects the list with status 2. No command is issued, and the remaining descriptors are consumed.
- R10: Nonzero reserved bits 28:8 abort the list with status 4. A STOP is sent only if the bus is held. The retry bit has no effect on commands or status.
- R11: A continuation descriptor whose direction bit differs from the direction of the last START aborts the list with status 3. A STOP follows, because the bus is held.
- R12: A descriptor of length 0 issues only its START and address, if it has them, and then moves to the next descriptor.
- R13: After reset, desc_ready is 1 and no command, read byte or completion is presented. Each list ends with exactly one one-cycle done_valid pulse. The pulse carries status 0 when no error occurred, and the bus is released by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor available |
| desc_ready | output | 1 | Descriptor accepted when high with desc_valid |
| desc_ctrl | input | 32 | Descriptor control word |
| desc_len | input | LEN_W | Byte count of the descriptor |
| desc_last | input | 1 | Descriptor ends the list |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Received byte taken |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command to the byte engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 START, 1 write, 2 read, 3 STOP |
| cmd_wdata | output | 8 | Byte for a write command |
| cmd_nack | output | 1 | Read command answers with NACK |
| rsp_valid | input | 1 | One-cycle response to the accepted command |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_rdata | input | 8 | Byte returned by a read command |
| done_valid | output | 1 | One-cycle list completion pulse |
| done_status | output | 3 | 0 ok, 1 no-ack, 2 bad first, 3 direction change, 4 reserved bits |
| done_sum | output | SUM_W | Checksum of the list |

## Verification
The bench builds the sequencer with LEN_W = 9 and SUM_W = 8. The narrow accumulator wraps many times within one checksum list of a few hundred bytes, so the modulo behaviour is checked in a short run. A 9-bit length lets a single descriptor cover hundreds of bytes while the count stays small enough to expose decrement and zero-length boundaries. The engine model stalls commands, delays responses and throttles both byte streams in fixed patterns. These stalls place lookahead reads and aborts at varied cycle offsets.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        STS_OK       = 3'd0,
        STS_NOACK    = 3'd1,
        STS_BADFIRST = 3'd2,
        STS_DIRFLIP  = 3'd3,
        STS_RSVD     = 3'd4
    } status_e;

    // bit order is fixed: neighbours build this word
    typedef struct packed {
        logic        chain;     // 31: continuation
        logic        sum_only;  // 30: checksum mode
        logic        retry;     // 29: hint, not used here
        logic [20:0] rsvd;      // 28:8
        logic [6:0]  dev;       // 7:1
        logic        rd;        // 0
    } ctrl_t;

endpackage

// File: rtl/i2c_seq_desc_chk.sv
module i2c_seq_desc_chk
    import i2c_seq_pkg::*;
(
    input  ctrl_t   ctrl,
    input  logic    first,
    input  logic    held_dir,
    output status_e verdict
);

    logic retry_unused;
    assign retry_unused = ctrl.retry;

    always_comb begin
        if (first && ctrl.chain) begin
            verdict = STS_BADFIRST;
        end else if (|ctrl.rsvd) begin
            verdict = STS_RSVD;
        end else if (!first && ctrl.chain && (ctrl.rd != held_dir)) begin
            verdict = STS_DIRFLIP;
        end else begin
            verdict = STS_OK;
        end
    end

endmodule

// File: rtl/i2c_seq_csum.sv
module i2c_seq_csum #(
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [7:0]       add_byte,
    output logic [SUM_W-1:0] sum
);

    typedef struct packed {
        logic [SUM_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d.acc = '0;
        end else if (add) begin
            acc_d.acc = acc_q.acc + SUM_W'(add_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum = acc_q.acc;

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [7:0]       desc_addr,
    input  logic             desc_sum,
    input  logic             desc_chain,
    input  logic             desc_rd,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_last,
    input  status_e          verdict,
    output logic             cur_first,
    output logic             cur_dir,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output op_e              cmd_op,
    output logic [7:0]       cmd_wdata,
    output logic             cmd_nack,
    input  logic             rsp_valid,
    input  logic             rsp_ack,
    input  logic [7:0]       rsp_rdata,
    output logic             sum_clr,
    output logic             sum_add,
    output logic             done_valid,
    output status_e          done_status
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef enum logic [3:0] {
        S_FETCH, S_START, S_ADDR, S_DATA, S_WRGET, S_WRITE,
        S_PEEK, S_READ, S_RDOUT, S_STOP, S_DRAIN, S_DONE
    } state_e;

    typedef struct packed {
        state_e           st;
        logic             wait_rsp;
        logic [7:0]       addr;
        logic             sum_only;
        logic [LEN_W-1:0] cnt;
        logic             last;
        logic             first;
        logic             held;
        logic             dir;
        logic [7:0]       dbyte;
        logic             nack;
        status_e          status;
    } regs_t;

    regs_t d, q;
    logic  is_cmd;
    logic  got;

    always_comb begin
        d           = q;
        desc_ready  = 1'b0;
        wr_ready    = 1'b0;
        rd_valid    = 1'b0;
        cmd_op      = OP_START;
        cmd_wdata   = 8'h00;
        cmd_nack    = 1'b0;
        sum_clr     = 1'b0;
        sum_add     = 1'b0;
        done_valid  = 1'b0;
        done_status = q.status;

        is_cmd    = (q.st == S_START) || (q.st == S_ADDR) || (q.st == S_WRITE) ||
                    (q.st == S_READ)  || (q.st == S_STOP);
        cmd_valid = is_cmd && !q.wait_rsp;
        got       = is_cmd && q.wait_rsp && rsp_valid;
        if (cmd_valid && cmd_ready) begin
            d.wait_rsp = 1'b1;
        end
        if (got) begin
            d.wait_rsp = 1'b0;
        end

        case (q.st)
            S_FETCH: begin
                desc_ready = 1'b1;
                if (desc_valid) begin
                    sum_clr    = q.first;
                    d.first    = 1'b0;
                    d.addr     = desc_addr;
                    d.sum_only = desc_sum;
                    d.cnt      = desc_len;
                    d.last     = desc_last;
                    if (verdict != STS_OK) begin
                        d.status = verdict;
                        if (q.held) begin
                            d.st = S_STOP;
                        end else if (desc_last) begin
                            d.st = S_DONE;
                        end else begin
                            d.st = S_DRAIN;
                        end
                    end else if (!desc_chain) begin
                        d.dir = desc_rd;
                        d.st  = S_START;
                    end else begin
                        d.st = S_DATA;
                    end
                end
            end
            S_START: begin
                cmd_op = OP_START;
                if (got) begin
                    d.held = 1'b1;
                    d.st   = S_ADDR;
                end
            end
            S_ADDR: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = q.addr;
                if (got) begin
                    if (rsp_ack) begin
                        d.st = S_DATA;
                    end else begin
                        d.status = STS_NOACK;
                        d.st     = S_STOP;
                    end
                end
            end
            S_DATA: begin
                if (q.cnt == '0) begin
                    d.st = q.last ? S_STOP : S_FETCH;
                end else if (!q.dir) begin
                    d.st = S_WRGET;
                end else if ((q.cnt == ONE) && !q.last) begin
                    d.st = S_PEEK;
                end else begin
                    d.nack = (q.cnt == ONE);
                    d.st   = S_READ;
                end
            end
            S_WRGET: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    d.dbyte = wr_data;
                    d.st    = S_WRITE;
                end
            end
            S_WRITE: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = q.dbyte;
                if (got) begin
                    if (rsp_ack) begin
                        d.cnt = q.cnt - ONE;
                        d.st  = S_DATA;
                    end else begin
                        d.status = STS_NOACK;
                        d.st     = S_STOP;
                    end
                end
            end
            S_PEEK: begin
                if (desc_valid) begin
                    d.nack = !desc_chain;
                    d.st   = S_READ;
                end
            end
            S_READ: begin
                cmd_op   = OP_READ;
                cmd_nack = q.nack;
                if (got) begin
                    d.dbyte = rsp_rdata;
                    d.cnt   = q.cnt - ONE;
                    if (q.sum_only) begin
                        sum_add = 1'b1;
                        d.st    = S_DATA;
                    end else begin
                        d.st = S_RDOUT;
                    end
                end
            end
            S_RDOUT: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    d.st = S_DATA;
                end
            end
            S_STOP: begin
                cmd_op = OP_STOP;
                if (got) begin
                    d.held = 1'b0;
                    d.st   = ((q.status != STS_OK) && !q.last) ? S_DRAIN : S_DONE;
                end
            end
            S_DRAIN: begin
                desc_ready = 1'b1;
                if (desc_valid && desc_last) begin
                    d.st = S_DONE;
                end
            end
            S_DONE: begin
                done_valid = 1'b1;
                d.first    = 1'b1;
                d.status   = STS_OK;
                d.st       = S_FETCH;
            end
            default: d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_FETCH;
            q.first <= 1'b1;
            q.status <= STS_OK;
        end else begin
            q <= d;
        end
    end

    assign rd_data   = q.dbyte;
    assign cur_first = q.first;
    assign cur_dir   = q.dir;

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [31:0]      desc_ctrl,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_last,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_wdata,
    output logic             cmd_nack,
    input  logic             rsp_valid,
    input  logic             rsp_ack,
    input  logic [7:0]       rsp_rdata,
    output logic             done_valid,
    output logic [2:0]       done_status,
    output logic [SUM_W-1:0] done_sum
);

    ctrl_t   ctrl_w;
    status_e verdict_w;
    status_e status_w;
    op_e     op_w;
    logic    first_w;
    logic    dir_w;
    logic    sum_clr_w;
    logic    sum_add_w;

    assign ctrl_w = ctrl_t'(desc_ctrl);

    i2c_seq_desc_chk u_chk_desc (
        .ctrl     (ctrl_w),
        .first    (first_w),
        .held_dir (dir_w),
        .verdict  (verdict_w)
    );

    i2c_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .desc_valid  (desc_valid),
        .desc_ready  (desc_ready),
        .desc_addr   ({ctrl_w.dev, ctrl_w.rd}),
        .desc_sum    (ctrl_w.sum_only),
        .desc_chain  (ctrl_w.chain),
        .desc_rd     (ctrl_w.rd),
        .desc_len    (desc_len),
        .desc_last   (desc_last),
        .verdict     (verdict_w),
        .cur_first   (first_w),
        .cur_dir     (dir_w),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_data     (wr_data),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (op_w),
        .cmd_wdata   (cmd_wdata),
        .cmd_nack    (cmd_nack),
        .rsp_valid   (rsp_valid),
        .rsp_ack     (rsp_ack),
        .rsp_rdata   (rsp_rdata),
        .sum_clr     (sum_clr_w),
        .sum_add     (sum_add_w),
        .done_valid  (done_valid),
        .done_status (status_w)
    );

    i2c_seq_csum #(.SUM_W(SUM_W)) u_csum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sum_clr_w),
        .add      (sum_add_w),
        .add_byte (rsp_rdata),
        .sum      (done_sum)
    );

    assign cmd_op      = op_w;
    assign done_status = status_w;

endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker
    import i2c_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_wdata,
    input logic       cmd_nack,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       done_valid
);

    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            if (cmd_op == OP_START) begin
                held_q <= 1'b1;
            end else if (cmd_op == OP_STOP) begin
                held_q <= 1'b0;
            end
        end
    end

    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) &&
                                    $stable(cmd_wdata) && $stable(cmd_nack));

    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    a_r7_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == OP_STOP) |-> held_q);

    a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && ((cmd_op == OP_WRITE) || (cmd_op == OP_READ)) |-> held_q);

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r13_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !held_q);

endmodule

bind i2c_xfer_seq i2c_seq_checker u_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cmd_nack   (cmd_nack),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .done_valid (done_valid)
);

// File: tb/tb_i2c_xfer_seq.sv
`timescale 1ns/1ps
module tb_i2c_xfer_seq;

    localparam int LEN_W = 9;
    localparam int SUM_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             desc_valid = 1'b0, desc_ready;
    logic [31:0]      desc_ctrl = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic             desc_last = 1'b0;
    logic             wr_valid = 1'b0, wr_ready;
    logic [7:0]       wr_data = '0;
    logic             rd_valid, rd_ready = 1'b0;
    logic [7:0]       rd_data;
    logic             cmd_valid, cmd_ready = 1'b0;
    logic [1:0]       cmd_op;
    logic [7:0]       cmd_wdata;
    logic             cmd_nack;
    logic             rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0]       rsp_rdata = '0;
    logic             done_valid;
    logic [2:0]       done_status;
    logic [SUM_W-1:0] done_sum;

    i2c_xfer_seq #(.LEN_W(LEN_W), .SUM_W(SUM_W)) dut (.*);

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    // stimulus and expectation queues
    logic [31:0]            lc[$];
    int                     ll[$];
    logic [32+LEN_W:0]      dq[$];
    logic [7:0]             wq[$];
    logic [10:0]            ec[$];
    logic [7:0]             er[$];
    logic [2+SUM_W:0]       ed[$];
    int wk = 0;
    int mrk = 0;
    int poison_wk = -1;

    // engine model state
    bit       s_pend = 0;
    int       s_dly = 0;
    bit       s_ack = 0;
    logic [7:0] s_data = '0;
    int       srk = 0;

    function automatic bit tgt_nacks(input logic [7:0] b);
        return (b == 8'hEE) || (b[7:1] == 7'h2A);
    endfunction

    function automatic logic [10:0] enc(input int op, input bit nk, input logic [7:0] b);
        return {2'(op), nk, b};
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0: return "R2 R12";
            2'd1: return "R1 R3";
            2'd2: return "R4 R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string sts_tag(input logic [2:0] s);
        case (s)
            3'd1: return "R8 R5";
            3'd2: return "R9 R5";
            3'd3: return "R11 R5";
            3'd4: return "R10 R5";
            default: return "R13 R5";
        endcase
    endfunction

    function automatic logic [31:0] mk(input bit rd, input logic [6:0] a, input bit chain,
                                       input bit sm, input bit rty, input logic [20:0] rs);
        return {chain, sm, rty, rs, a, rd};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic add(input logic [31:0] c, input int n);
        lc.push_back(c);
        ll.push_back(n);
    endtask

    function automatic logic [7:0] next_wr();
        logic [7:0] b;
        b = (wk == poison_wk) ? 8'hEE : 8'(8'h10 + (wk % 48));
        wk++;
        return b;
    endfunction

    // behavioural reference for one list
    task automatic plan_list();
        int n = lc.size();
        int st = 0;
        logic [SUM_W-1:0] sm = '0;
        bit held = 0;
        bit dir = 0;
        bit abort = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] c;
            bit last;
            int err;
            c = lc[i];
            last = (i == n - 1);
            err = 0;
            dq.push_back({c, LEN_W'(ll[i]), last});
            if (!abort) begin
                if (i == 0 && c[31]) err = 2;
                else if (c[28:8] != 0) err = 4;
                else if (i > 0 && c[31] && (c[0] != dir)) err = 3;
                if (err != 0) begin
                    st = err;
                    if (held) ec.push_back(enc(3, 0, 8'h00));
                    held = 0;
                    abort = 1;
                end else begin
                    if (!c[31]) begin
                        ec.push_back(enc(0, 0, 8'h00));
                        held = 1;
                        dir = c[0];
                        ec.push_back(enc(1, 0, c[7:0]));
                        if (tgt_nacks(c[7:0])) begin
                            st = 1;
                            ec.push_back(enc(3, 0, 8'h00));
                            held = 0;
                            abort = 1;
                        end
                    end
                    for (int b = 0; b < ll[i] && !abort; b++) begin
                        if (!dir) begin
                            logic [7:0] w;
                            w = next_wr();
                            wq.push_back(w);
                            ec.push_back(enc(1, 0, w));
                            if (tgt_nacks(w)) begin
                                st = 1;
                                ec.push_back(enc(3, 0, 8'h00));
                                held = 0;
                                abort = 1;
                            end
                        end else begin
                            bit nk;
                            logic [7:0] r;
                            nk = (b == ll[i] - 1) && (last || !lc[i+1][31]);
                            ec.push_back(enc(2, nk, 8'h00));
                            r = 8'(8'hA0 + 3 * mrk);
                            mrk++;
                            if (c[30]) sm = sm + SUM_W'(r);
                            else er.push_back(r);
                        end
                    end
                    if (!abort && last) begin
                        ec.push_back(enc(3, 0, 8'h00));
                        held = 0;
                    end
                end
            end
        end
        ed.push_back({3'(st), sm});
        lc.delete();
        ll.delete();
    endtask

    task automatic run_list();
        plan_list();
        while (ed.size() != 0) @(negedge clk);
    endtask

    // port-level model and per-clock comparison
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            cmd_ready  = (cyc % 4) != 1;
            rd_ready   = (cyc % 3) != 0;
            rsp_valid  = s_pend && (s_dly == 0);
            rsp_ack    = s_ack;
            rsp_rdata  = s_data;
            desc_valid = dq.size() > 0;
            if (dq.size() > 0) {desc_ctrl, desc_len, desc_last} = dq[0];
            wr_valid   = (wq.size() > 0) && ((cyc % 5) != 2);
            wr_data    = (wq.size() > 0) ? wq[0] : 8'h00;
            #4;
            if (rsp_valid) s_pend = 0;
            else if (s_pend && s_dly > 0) s_dly--;
            if (desc_valid && desc_ready) void'(dq.pop_front());
            if (wr_valid && wr_ready) void'(wq.pop_front());
            if (cmd_valid && cmd_ready) begin
                logic [10:0] got;
                got = {cmd_op, (cmd_op == 2'd2) ? cmd_nack : 1'b0,
                       (cmd_op == 2'd1) ? cmd_wdata : 8'h00};
                if (ec.size() == 0) begin
                    check(0, op_tag(cmd_op), "unexpected command", 64'(got), 64'h7ff);
                end else begin
                    logic [10:0] e;
                    e = ec.pop_front();
                    check(got == e, op_tag(e[10:9]), "command", 64'(got), 64'(e));
                end
                s_pend = 1;
                s_dly  = cyc % 3;
                s_ack  = (cmd_op == 2'd1) ? !tgt_nacks(cmd_wdata) : 1'b1;
                s_data = 8'h00;
                if (cmd_op == 2'd2) begin
                    s_data = 8'(8'hA0 + 3 * srk);
                    srk++;
                end
            end
            if (rd_valid && rd_ready) begin
                if (er.size() == 0) begin
                    check(0, "R4 R5", "unexpected read byte", 64'(rd_data), 64'hff);
                end else begin
                    logic [7:0] e;
                    e = er.pop_front();
                    check(rd_data == e, "R4", "read byte", 64'(rd_data), 64'(e));
                end
            end
            if (done_valid) begin
                if (ed.size() == 0) begin
                    check(0, "R13", "unexpected done", 64'(done_status), 64'h7);
                end else begin
                    logic [2+SUM_W:0] e;
                    e = ed.pop_front();
                    check({done_status, done_sum} == e, sts_tag(e[2+SUM_W:SUM_W]),
                          "done status/sum", 64'({done_status, done_sum}), 64'(e));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R13 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        check(desc_ready == 1'b1 && cmd_valid == 1'b0 && rd_valid == 1'b0 &&
              done_valid == 1'b0 && wr_ready == 1'b0, "R13", "reset state",
              64'({desc_ready, cmd_valid, rd_valid, done_valid, wr_ready}), 64'h10);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 single write
        add(mk(0, 7'h21, 0, 0, 0, 0), 3);
        run_list();
        // R2 write continued without START
        add(mk(0, 7'h21, 0, 0, 0, 0), 2);
        add(mk(0, 7'h21, 1, 0, 0, 0), 2);
        run_list();
        // R1 repeated START into a read, R6 final NACK
        add(mk(0, 7'h33, 0, 0, 0, 0), 1);
        add(mk(1, 7'h33, 0, 0, 0, 0), 4);
        run_list();
        // R6 ACK across continuation, NACK before a new START
        add(mk(1, 7'h40, 0, 0, 0, 0), 3);
        add(mk(1, 7'h40, 1, 0, 0, 0), 2);
        add(mk(1, 7'h41, 0, 0, 0, 0), 2);
        run_list();
        // R5 checksum, wrapping the narrow accumulator, mixed with forwarding
        add(mk(1, 7'h50, 0, 0, 0, 0), 2);
        add(mk(1, 7'h50, 1, 1, 0, 0), 300);
        run_list();
        // R5 accumulator cleared for the next list
        add(mk(1, 7'h51, 0, 1, 0, 0), 5);
        run_list();
        // R8 address NACK with descriptors to drain
        add(mk(0, 7'h2A, 0, 0, 0, 0), 2);
        add(mk(0, 7'h2A, 1, 0, 0, 0), 3);
        add(mk(1, 7'h22, 0, 0, 0, 0), 2);
        run_list();
        // R8 data NACK inside the second descriptor
        poison_wk = wk + 3;
        add(mk(0, 7'h23, 0, 0, 0, 0), 2);
        add(mk(0, 7'h23, 1, 0, 0, 0), 4);
        add(mk(0, 7'h23, 0, 0, 0, 0), 2);
        run_list();
        poison_wk = -1;
        // R9 continuation as first descriptor
        add(mk(0, 7'h24, 1, 0, 0, 0), 2);
        add(mk(0, 7'h24, 0, 0, 0, 0), 2);
        run_list();
        // R10 reserved bits mid-list (bus held) and on the first descriptor
        add(mk(0, 7'h25, 0, 0, 0, 0), 1);
        add(mk(0, 7'h25, 1, 0, 0, 21'h000100), 1);
        add(mk(0, 7'h25, 0, 0, 0, 0), 1);
        run_list();
        add(mk(0, 7'h26, 0, 0, 0, 21'h100000), 1);
        run_list();
        // R11 direction flip in a continuation
        add(mk(0, 7'h27, 0, 0, 0, 0), 1);
        add(mk(1, 7'h27, 1, 0, 0, 0), 2);
        run_list();
        // R12 zero-length probe, R10 retry bit has no effect
        add(mk(0, 7'h28, 0, 0, 1, 0), 0);
        run_list();
        add(mk(1, 7'h29, 0, 0, 1, 0), 0);
        add(mk(0, 7'h29, 0, 0, 0, 0), 0);
        add(mk(1, 7'h29, 0, 1, 1, 0), 3);
        run_list();

        repeat (5) @(negedge clk);
        check(ec.size() == 0, "R7", "commands left", 64'(ec.size()), 64'd0);
        check(er.size() == 0, "R4", "read bytes left", 64'(er.size()), 64'd0);
        check(wq.size() == 0 && dq.size() == 0, "R3", "stimulus left",
              64'(wq.size() + dq.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule